// File: doc/BRIEF.md
# Two-Bank GPIO Controller with Edge Interrupts

This block is a 32-pin general-purpose I/O controller on a small word-addressed register bus. The pins form two banks of sixteen: bank 0 holds pins 0 to 15 and bank 1 holds pins 16 to 31. Each pin is an input or an output, chosen by a direction register. Output levels can be written directly. They can also be changed through write-one set and clear registers, so independent software tasks can change pins without a read-modify-write and without locking.

Every pin passes through a two-flop synchronizer. Each pin can watch for rising edges, falling edges or both. A detected edge on an armed pin latches a status bit, which software clears by writing a one to it. Bank 0 gives one interrupt pulse per pin, and pins 0 to 9 also give a DMA event pulse. Bank 1 is merged into one level interrupt that stays high while any of its status bits is set. A per-bank enable register gates each bank's outputs.

Top module: `gpio_banked`

## Requirements
- R1: After reset every pin is an input (`pin_oe` all 0), the output register and `pin_out` are 0, all edge enables and status bits are 0, the bank enable register (word 2) reads 0, and no interrupt or DMA event is active.
- R2: The direction register (word 4) reads back as written. A 1 bit makes the pin an input and a 0 bit makes it an output, and `pin_oe` is the bitwise inverse of the register.
- R3: Writing the output register (word 5) replaces all drive values, and `pin_out` follows it. Reading word 5 returns the drive values and never the pin levels.
- R4: A write to word 6 sets every output bit where the write data is 1. A write to word 7 clears every output bit where the write data is 1. Zero bits leave the output unchanged.
- R5: Reading word 8 returns the pin levels after the two-flop synchronizer, for input and output pins alike. A pin change is visible in word 8 two clock edges after it is applied.
- R6: Rising enables are set by writing ones to word 9 and cleared by writing ones to word 10. Falling enables use words 11 and 12 in the same way. A read of either word of a pair returns that pair's current mask.
- R7: A synchronized rising edge on a pin with its rising enable set, or a falling edge on a pin with its falling enable set, sets the pin's bit in the status register (word 13). An edge on a pin without the matching enable sets nothing.
- R8: Writing to word 13 clears each status bit where the data is 1 and leaves bits where the data is 0.
- R9: For bank 0, `irq_pin[i]` is a one-clock pulse in the cycle in which an enabled edge on pin i is detected, and `dma_evt[i]` does the same for pins 0 to 9. Both are suppressed while bit 0 of the bank enable register is 0, but status is still recorded.
- R10: `irq_bank1` is high while bit 1 of the bank enable register is 1 and any status bit of pins 16 to 31 is set. Only bits 1:0 of word 2 are kept.
- R11: Word 0 returns the fixed identification value 0x47503210 and ignores writes. Words 1, 3, 14 and 15 read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word (combinational) |
| pin_in | input | 32 | Pin levels from the pads (asynchronous) |
| pin_out | output | 32 | Output drive values |
| pin_oe | output | 32 | Output enable per pin, 1 = driving |
| irq_pin | output | 16 | Per-pin interrupt pulses for bank 0 |
| irq_bank1 | output | 1 | Merged level interrupt for bank 1 |
| dma_evt | output | 10 | DMA event pulses for pins 0 to 9 |

## Verification
The pulse-width checks assume that each pin holds its level for at least two clocks between changes. If it does not, one pin can produce detected edges in back-to-back cycles. The bench drives pins only at falling clock edges and waits four or more cycles after each change. The status assertions assume bus inputs stay low during reset. The bench keeps `bus_sel` and `bus_wr` at 0 until reset is released and raises them for exactly one cycle per access.

// File: rtl/gpio_bk_pkg.sv
package gpio_bk_pkg;

  typedef enum logic [3:0] {
    SEL_IDENT   = 4'd0,
    SEL_BANKEN  = 4'd2,
    SEL_DIR     = 4'd4,
    SEL_OUT     = 4'd5,
    SEL_OUTSET  = 4'd6,
    SEL_OUTCLR  = 4'd7,
    SEL_IN      = 4'd8,
    SEL_RISESET = 4'd9,
    SEL_RISECLR = 4'd10,
    SEL_FALLSET = 4'd11,
    SEL_FALLCLR = 4'd12,
    SEL_STATUS  = 4'd13
  } reg_sel_e;

  localparam int unsigned NUM_BANKS = 2;

endpackage

// File: rtl/gpio_bk_sync.sv
module gpio_bk_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);

  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;
  logic [WIDTH-1:0] prev_q;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage1_q[i] <= 1'b0;
          stage2_q[i] <= 1'b0;
          prev_q[i]   <= 1'b0;
        end else begin
          stage1_q[i] <= pin_in[i];
          stage2_q[i] <= stage1_q[i];
          prev_q[i]   <= stage2_q[i];
        end
      end
      assign rise[i] = stage2_q[i] & ~prev_q[i];
      assign fall[i] = ~stage2_q[i] & prev_q[i];
    end
  endgenerate

  assign level = stage2_q;

  // A pin held at least two clocks never shows edges in consecutive cycles
  AST_EDGE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rise | fall)) |=> (((rise | fall) & $past(rise | fall)) == '0)); // R7

endmodule

// File: rtl/gpio_bk_regfile.sv
module gpio_bk_regfile
  import gpio_bk_pkg::*;
#(
  parameter int unsigned BANK_W   = 16,
  parameter int unsigned ID_VALUE = 32'h4750_3210,
  localparam int unsigned W       = 2 * BANK_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [3:0]           bus_addr,
  input  logic [W-1:0]         bus_wdata,
  input  logic [W-1:0]         in_level,
  input  logic [W-1:0]         status,
  output logic [W-1:0]         dir_q,
  output logic [W-1:0]         out_q,
  output logic [W-1:0]         rise_en_q,
  output logic [W-1:0]         fall_en_q,
  output logic [NUM_BANKS-1:0] bank_en_q,
  output logic                 stat_clr_we,
  output logic [W-1:0]         stat_clr_data,
  output logic [W-1:0]         bus_rdata
);

  function automatic logic [W-1:0] set_clear(input logic [W-1:0] cur,
                                             input logic [W-1:0] set_m,
                                             input logic [W-1:0] clr_m);
    return (cur | set_m) & ~clr_m;
  endfunction

  reg_sel_e sel;
  logic     wr_en;
  logic     out_touch;
  logic     trig_touch;

  assign sel        = reg_sel_e'(bus_addr);
  assign wr_en      = bus_sel & bus_wr;
  assign out_touch  = wr_en && (sel == SEL_OUT || sel == SEL_OUTSET || sel == SEL_OUTCLR);
  assign trig_touch = wr_en && (sel == SEL_RISESET || sel == SEL_RISECLR ||
                                sel == SEL_FALLSET || sel == SEL_FALLCLR);

  assign stat_clr_we   = wr_en && (sel == SEL_STATUS);
  assign stat_clr_data = bus_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q     <= '1;
      out_q     <= '0;
      rise_en_q <= '0;
      fall_en_q <= '0;
      bank_en_q <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_BANKEN:  bank_en_q <= bus_wdata[NUM_BANKS-1:0];
        SEL_DIR:     dir_q     <= bus_wdata;
        SEL_OUT:     out_q     <= bus_wdata;
        SEL_OUTSET:  out_q     <= set_clear(out_q, bus_wdata, '0);
        SEL_OUTCLR:  out_q     <= set_clear(out_q, '0, bus_wdata);
        SEL_RISESET: rise_en_q <= set_clear(rise_en_q, bus_wdata, '0);
        SEL_RISECLR: rise_en_q <= set_clear(rise_en_q, '0, bus_wdata);
        SEL_FALLSET: fall_en_q <= set_clear(fall_en_q, bus_wdata, '0);
        SEL_FALLCLR: fall_en_q <= set_clear(fall_en_q, '0, bus_wdata);
        default: ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (sel)
      SEL_IDENT:   bus_rdata = W'(ID_VALUE);
      SEL_BANKEN:  bus_rdata = W'(bank_en_q);
      SEL_DIR:     bus_rdata = dir_q;
      SEL_OUT:     bus_rdata = out_q;
      SEL_OUTSET:  bus_rdata = out_q;
      SEL_OUTCLR:  bus_rdata = out_q;
      SEL_IN:      bus_rdata = in_level;
      SEL_RISESET: bus_rdata = rise_en_q;
      SEL_RISECLR: bus_rdata = rise_en_q;
      SEL_FALLSET: bus_rdata = fall_en_q;
      SEL_FALLCLR: bus_rdata = fall_en_q;
      SEL_STATUS:  bus_rdata = status;
      default:     bus_rdata = '0;
    endcase
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !out_touch |=> $stable(out_q)); // R3
  AST_SET_DRIVES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_OUTSET) |=> ((out_q & $past(bus_wdata)) == $past(bus_wdata))); // R4
  AST_CLR_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_OUTCLR) |=> ((out_q & $past(bus_wdata)) == '0)); // R4
  AST_TRIG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_touch |=> ($stable(rise_en_q) && $stable(fall_en_q))); // R6

endmodule

// File: rtl/gpio_bk_irq.sv
module gpio_bk_irq
  import gpio_bk_pkg::*;
#(
  parameter int unsigned BANK_W = 16,
  parameter int unsigned DMA_N  = 10,
  localparam int unsigned W     = 2 * BANK_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [W-1:0]         rise,
  input  logic [W-1:0]         fall,
  input  logic [W-1:0]         rise_en,
  input  logic [W-1:0]         fall_en,
  input  logic [NUM_BANKS-1:0] bank_en,
  input  logic                 stat_clr_we,
  input  logic [W-1:0]         stat_clr_data,
  output logic [W-1:0]         status,
  output logic [BANK_W-1:0]    irq_pin,
  output logic                 irq_bank1,
  output logic [DMA_N-1:0]     dma_evt
);

  function automatic logic [W-1:0] armed_edges(input logic [W-1:0] r,
                                               input logic [W-1:0] f,
                                               input logic [W-1:0] re,
                                               input logic [W-1:0] fe);
    return (r & re) | (f & fe);
  endfunction

  function automatic logic [W-1:0] status_step(input logic [W-1:0] cur,
                                               input logic [W-1:0] hit,
                                               input logic [W-1:0] clr);
    return (cur & ~clr) | hit;
  endfunction

  logic [W-1:0] edge_hit;
  logic [W-1:0] clr_mask;

  assign edge_hit = armed_edges(rise, fall, rise_en, fall_en);
  assign clr_mask = stat_clr_we ? stat_clr_data : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= status_step(status, edge_hit, clr_mask);
  end

  assign irq_pin   = bank_en[0] ? edge_hit[BANK_W-1:0] : '0;
  assign irq_bank1 = bank_en[1] & (|status[W-1:BANK_W]);

  generate
    for (genvar i = 0; i < DMA_N; i++) begin : g_dma
      assign dma_evt[i] = irq_pin[i];
    end
  endgenerate

  AST_STATUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_hit) |=> ((status & $past(edge_hit)) == $past(edge_hit))); // R7
  AST_STATUS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stat_clr_we) |-> ((status & $past(stat_clr_data & ~edge_hit)) == '0)); // R8
  AST_DMA_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (|dma_evt) |=> ((dma_evt & $past(dma_evt)) == '0)); // R9
  AST_BANK1_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(irq_bank1) && $past(bank_en[1]) && bank_en[1]) |-> $past(stat_clr_we)); // R10

endmodule

// File: rtl/gpio_banked.sv
module gpio_banked
  import gpio_bk_pkg::*;
#(
  parameter int unsigned BANK_W   = 16,
  parameter int unsigned DMA_N    = 10,
  parameter int unsigned ID_VALUE = 32'h4750_3210,
  localparam int unsigned W       = 2 * BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [3:0]        bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      pin_in,
  output logic [W-1:0]      pin_out,
  output logic [W-1:0]      pin_oe,
  output logic [BANK_W-1:0] irq_pin,
  output logic              irq_bank1,
  output logic [DMA_N-1:0]  dma_evt
);

  logic [W-1:0]         level;
  logic [W-1:0]         rise;
  logic [W-1:0]         fall;
  logic [W-1:0]         status;
  logic [W-1:0]         dir_q;
  logic [W-1:0]         out_q;
  logic [W-1:0]         rise_en_q;
  logic [W-1:0]         fall_en_q;
  logic [NUM_BANKS-1:0] bank_en_q;
  logic                 stat_clr_we;
  logic [W-1:0]         stat_clr_data;

  gpio_bk_sync #(.WIDTH(W)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_in (pin_in),
    .level  (level),
    .rise   (rise),
    .fall   (fall)
  );

  gpio_bk_regfile #(.BANK_W(BANK_W), .ID_VALUE(ID_VALUE)) u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_sel       (bus_sel),
    .bus_wr        (bus_wr),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .in_level      (level),
    .status        (status),
    .dir_q         (dir_q),
    .out_q         (out_q),
    .rise_en_q     (rise_en_q),
    .fall_en_q     (fall_en_q),
    .bank_en_q     (bank_en_q),
    .stat_clr_we   (stat_clr_we),
    .stat_clr_data (stat_clr_data),
    .bus_rdata     (bus_rdata)
  );

  gpio_bk_irq #(.BANK_W(BANK_W), .DMA_N(DMA_N)) u_irq (
    .clk           (clk),
    .rst_n         (rst_n),
    .rise          (rise),
    .fall          (fall),
    .rise_en       (rise_en_q),
    .fall_en       (fall_en_q),
    .bank_en       (bank_en_q),
    .stat_clr_we   (stat_clr_we),
    .stat_clr_data (stat_clr_data),
    .status        (status),
    .irq_pin       (irq_pin),
    .irq_bank1     (irq_bank1),
    .dma_evt       (dma_evt)
  );

  assign pin_out = out_q;
  assign pin_oe  = ~dir_q;

endmodule

// File: tb/gpio_banked_tb.sv
module gpio_banked_tb;

  localparam logic [31:0] ID_EXP = 32'h4750_3210;

  typedef struct packed {
    logic        rd;
    logic [3:0]  addr;
    logic [31:0] data;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 32;
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 4'd0,  ID_EXP,        4'd11},  // R11 identification
    '{1'b0, 4'd0,  32'hFFFF_FFFF, 4'd11},  // R11 write ignored
    '{1'b1, 4'd0,  ID_EXP,        4'd11},  // R11
    '{1'b0, 4'd1,  32'hFFFF_FFFF, 4'd11},  // R11 reserved write
    '{1'b1, 4'd1,  32'h0,         4'd11},  // R11 reserved reads 0
    '{1'b1, 4'd4,  32'hFFFF_FFFF, 4'd1},   // R1 all inputs
    '{1'b1, 4'd5,  32'h0,         4'd1},   // R1 outputs clear
    '{1'b1, 4'd9,  32'h0,         4'd1},   // R1 rise enables off
    '{1'b1, 4'd13, 32'h0,         4'd1},   // R1 status clear
    '{1'b1, 4'd2,  32'h0,         4'd1},   // R1 bank enables off
    '{1'b0, 4'd5,  32'hA5A5_0F0F, 4'd3},   // R3 direct write
    '{1'b1, 4'd5,  32'hA5A5_0F0F, 4'd3},   // R3
    '{1'b0, 4'd6,  32'h0000_F0F0, 4'd4},   // R4 set
    '{1'b1, 4'd5,  32'hA5A5_FFFF, 4'd4},   // R4
    '{1'b0, 4'd7,  32'h0000_0F00, 4'd4},   // R4 clear
    '{1'b1, 4'd5,  32'hA5A5_F0FF, 4'd4},   // R4
    '{1'b0, 4'd6,  32'h0,         4'd4},   // R4 zero set
    '{1'b0, 4'd7,  32'h0,         4'd4},   // R4 zero clear
    '{1'b1, 4'd5,  32'hA5A5_F0FF, 4'd4},   // R4 unchanged
    '{1'b0, 4'd4,  32'h0000_FFFF, 4'd2},   // R2 bank 1 outputs
    '{1'b1, 4'd4,  32'h0000_FFFF, 4'd2},   // R2
    '{1'b0, 4'd9,  32'h0000_0003, 4'd6},   // R6 rise set
    '{1'b0, 4'd9,  32'h0001_0000, 4'd6},   // R6
    '{1'b1, 4'd10, 32'h0001_0003, 4'd6},   // R6 read via clear word
    '{1'b0, 4'd10, 32'h0000_0001, 4'd6},   // R6 rise clear
    '{1'b1, 4'd9,  32'h0001_0002, 4'd6},   // R6
    '{1'b0, 4'd11, 32'h0000_0006, 4'd6},   // R6 fall set
    '{1'b1, 4'd12, 32'h0000_0006, 4'd6},   // R6
    '{1'b1, 4'd11, 32'h0000_0006, 4'd6},   // R6
    '{1'b0, 4'd2,  32'hFFFF_FFFF, 4'd10},  // R10 only two bits kept
    '{1'b1, 4'd2,  32'h0000_0003, 4'd10},  // R10
    '{1'b1, 4'd14, 32'h0,         4'd11}   // R11 unused word
  };

  logic        clk;
  logic        rst_n;
  logic        bus_sel;
  logic        bus_wr;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in;
  logic [31:0] pin_out;
  logic [31:0] pin_oe;
  logic [15:0] irq_pin;
  logic        irq_bank1;
  logic [9:0]  dma_evt;

  int errors = 0;
  int checks = 0;
  int pcnt [16];
  int dcnt [10];
  bit done = 0;

  gpio_banked u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq_pin   (irq_pin),
    .irq_bank1 (irq_bank1),
    .dma_evt   (dma_evt)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial begin
    for (int i = 0; i < 16; i++) pcnt[i] = 0;
    for (int i = 0; i < 10; i++) dcnt[i] = 0;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < 16; i++) if (irq_pin[i]) pcnt[i] = pcnt[i] + 1;
      for (int i = 0; i < 10; i++) if (dma_evt[i]) dcnt[i] = dcnt[i] + 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic read_check(input string tag, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] d;
    bus_read(a, d);
    check(tag, d, exp);
  endtask

  task automatic drive_pin(input int idx, input logic v);
    @(negedge clk);
    pin_in[idx] = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int before_p, before_d;
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; pin_in = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state at the ports
    check("R1 pin_oe", pin_oe, 32'h0);
    check("R1 pin_out", pin_out, 32'h0);
    check("R1 irq_pin", {16'h0, irq_pin}, 32'h0);
    check("R1 irq_bank1", {31'h0, irq_bank1}, 32'h0);
    check("R1 dma_evt", {22'h0, dma_evt}, 32'h0);

    // R5 synchronizer latency, enables still off
    @(negedge clk);
    pin_in = 32'h5A00_0C30;
    read_check("R5 one edge after change", 4'd8, 32'h0);
    read_check("R5 two edges after change", 4'd8, 32'h5A00_0C30);

    // Register table
    for (int k = 0; k < NVEC; k++) begin
      if (VEC[k].rd) begin
        bus_read(VEC[k].addr, d);
        checks++;
        if (d !== VEC[k].data) begin
          errors++;
          $display("FAIL R%0d vec %0d word %0d actual=%h expected=%h",
                   VEC[k].req, k, VEC[k].addr, d, VEC[k].data);
        end
      end else begin
        bus_write(VEC[k].addr, VEC[k].data);
      end
    end

    #1;
    check("R2 pin_oe after direction write", pin_oe, 32'hFFFF_0000);
    check("R3 pin_out follows register", pin_out, 32'hA5A5_F0FF);
    read_check("R5 input word ignores direction and drive", 4'd8, 32'h5A00_0C30);

    // Edge tests. rise = pins 1,16 ; add pins 0,20. fall = pins 1,2.
    bus_write(4'd9, 32'h0010_0001);
    bus_write(4'd13, 32'hFFFF_FFFF);
    read_check("R8 full clear", 4'd13, 32'h0);

    // R9 exact pulse timing on pin 0
    drive_pin(0, 1'b1);
    @(negedge clk);
    @(negedge clk);
    #1;
    check("R9 irq_pin pulse", {16'h0, irq_pin}, 32'h0000_0001);
    check("R9 dma_evt pulse", {22'h0, dma_evt}, 32'h0000_0001);
    @(negedge clk);
    #1;
    check("R9 irq_pin one cycle", {16'h0, irq_pin}, 32'h0);
    read_check("R7 rising edge latched", 4'd13, 32'h0000_0001);

    // R7 unarmed pin 3
    drive_pin(3, 1'b1);
    idle(4);
    read_check("R7 unarmed edge ignored", 4'd13, 32'h0000_0001);
    check("R7 no pulse on pin 3", pcnt[3], 0);

    // R7 / R8 pin 1 armed for both edges
    drive_pin(1, 1'b1);
    idle(4);
    read_check("R7 pin 1 rising", 4'd13, 32'h0000_0003);
    bus_write(4'd13, 32'h0000_0002);
    read_check("R8 partial clear", 4'd13, 32'h0000_0001);
    drive_pin(1, 1'b0);
    idle(4);
    read_check("R7 pin 1 falling", 4'd13, 32'h0000_0003);
    check("R9 pin 1 two pulses", pcnt[1], 2);
    bus_write(4'd13, 32'h0);
    read_check("R8 zero write keeps bits", 4'd13, 32'h0000_0003);

    // R7 pin 2 falling only
    drive_pin(2, 1'b1);
    idle(4);
    read_check("R7 fall-only ignores rise", 4'd13, 32'h0000_0003);
    drive_pin(2, 1'b0);
    idle(4);
    read_check("R7 fall-only catches fall", 4'd13, 32'h0000_0007);

    // R10 bank 1 merged level
    #1;
    check("R10 idle low", {31'h0, irq_bank1}, 32'h0);
    drive_pin(20, 1'b1);
    idle(4);
    #1;
    check("R10 asserted by pin 20", {31'h0, irq_bank1}, 32'h1);
    idle(3);
    #1;
    check("R10 stays asserted", {31'h0, irq_bank1}, 32'h1);
    read_check("R7 pin 20 status", 4'd13, 32'h0010_0007);
    bus_write(4'd13, 32'hFFFF_0000);
    #1;
    check("R10 drops after clear", {31'h0, irq_bank1}, 32'h0);
    read_check("R8 bank 0 bits kept", 4'd13, 32'h0000_0007);
    drive_pin(20, 1'b0);
    idle(4);
    drive_pin(20, 1'b1);
    idle(4);
    #1;
    check("R10 reasserted", {31'h0, irq_bank1}, 32'h1);
    bus_write(4'd2, 32'h0000_0001);
    #1;
    check("R10 gated by bank enable", {31'h0, irq_bank1}, 32'h0);
    read_check("R10 status kept while gated", 4'd13, 32'h0010_0007);

    // R9 bank 0 gating: status still recorded
    bus_write(4'd2, 32'h0000_0002);
    bus_write(4'd13, 32'h0000_0001);
    before_p = pcnt[0];
    before_d = dcnt[0];
    drive_pin(0, 1'b0);
    idle(4);
    drive_pin(0, 1'b1);
    idle(4);
    check("R9 gated irq_pin", pcnt[0], before_p);
    check("R9 gated dma_evt", dcnt[0], before_d);
    read_check("R9 gated edge still latched", 4'd13, 32'h0010_0007);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule